// File: doc/BRIEF.md
# Voltage Regulator Soft-Start Sequencer

This block brings a regulator's reference up from zero in a controlled way. The reference is a DAC code with a fixed millivolt weight per step. Nothing happens until the supply-good input and both enable inputs are high. After that the block waits a fixed start-up time. It then raises the code by one step per soft-start oscillator tick until it reaches an intermediate level. The block holds that level while it qualifies an identification code. It then steps the code toward the target that the identification code gives, up or down. After a timed settle it raises ready.

All timings are clock-cycle counts given as parameters. With the defaults, a 200 MHz clock and 6.25 mV steps, the start-up delay is 1.36 ms, the hold and settle times are 85 us, and the intermediate level is code 176 (1.1 V). The identification code is taken directly as a DAC code. The target is that code minus a configured offset, floored at zero. The oscillator that makes the step ticks and the analog loop are outside the block.

Top module: `vr_softstart_seq`

## Requirements
- R1: While `rst` is high, and on the clock edge after any of `por_ok`, `en_core` or `en_io` is low, `phase` is 0 (off), `dac_code` is 0 and `ready` is 0.
- R2: With all three supply and enable inputs high in phase 0, and no off code presented, the block enters phase 1 (start-up delay) on the next edge and stays there for exactly `START_CYC` cycles.
- R3: `dac_code` changes only in phases 2 and 4, only on an edge where `step_tick` was high, and only by exactly one code (clearing to 0 on shutdown or fault excepted).
- R4: In phase 2 the code rises from 0 to `MID_CODE`, one step per tick, and the block then moves to phase 3 (hold) with `dac_code` equal to `MID_CODE`.
- R5: Phase 3 lasts at least `HOLD_CYC` cycles and ends only once `id_valid` has been high with an unchanged `id_code` for `ID_STABLE_CYC` consecutive edges. If that is already true when the hold time ends, phase 3 lasts exactly `HOLD_CYC` cycles. If a code is presented later, the block leaves phase 3 on the (`ID_STABLE_CYC`+2)th edge after it is presented. If no valid code is ever presented, the block stays in phase 3 with the code at `MID_CODE`.
- R6: In phase 4 the code steps toward the target `id_code - OFFSET_STEPS`, floored at 0, counting down when the target is below `MID_CODE`. It ends at the target exactly.
- R7: Phase 5 (settle) lasts exactly `SETTLE_CYC` cycles, then phase 6 (ready) with `ready` high. `ready` is high only in phase 6.
- R8: An off code (`id_valid` high and `id_code` equal to `OFF_CODE`) sends the block to phase 0 on the next edge. This applies when the code is qualified at the end of the hold, or whenever it is seen in phases 4 to 6. Phase 0 is held while the off code remains.
- R9: `fault_in` high in phases 1 to 6 sends the block to phase 7 (fault) on the next edge, with `dac_code` 0 and `ready` 0. The block stays in phase 7 until reset or until a supply or enable input drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_ok | input | 1 | Supply has passed its power-on threshold |
| en_core | input | 1 | First enable |
| en_io | input | 1 | Second enable |
| step_tick | input | 1 | One-cycle strobe from the soft-start oscillator |
| id_code | input | CODE_W | Identification code, read as a DAC code |
| id_valid | input | 1 | Identification code is driven |
| fault_in | input | 1 | Fault request |
| dac_code | output | CODE_W | Reference DAC code |
| phase | output | 3 | Sequencer phase, 0 off to 7 fault |
| ready | output | 1 | Reference settled at target |

## Verification
The bench runs a small configuration and sweeps every identification code from 1 to 40. This covers targets above, equal to and below the intermediate level, and the floor at zero. A design that counted only upward, or that stopped one step short, would show a wrong final code. It also times each phase against its parameter, so an off-by-one delay counter is caught. Separate runs present the identification code late, never, and as the off code. They also raise a fault and then release it. A design that left the hold early, ignored the off code, or left the fault state before an enable dropped would show the wrong phase.

// File: rtl/vr_ss_pkg.sv
package vr_ss_pkg;

  localparam int PHASE_W = 3;

  typedef enum logic [PHASE_W-1:0] {
    PH_OFF     = 3'd0,
    PH_DELAY   = 3'd1,
    PH_RAMP_UP = 3'd2,
    PH_HOLD    = 3'd3,
    PH_RAMP_ID = 3'd4,
    PH_SETTLE  = 3'd5,
    PH_READY   = 3'd6,
    PH_FAULT   = 3'd7
  } ss_phase_e;

endpackage

// File: rtl/vr_ss_timer.sv
// Phase dwell timer: done is high in the LIMIT-th cycle of run.
module vr_ss_timer #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt != LAST) begin
      cnt <= cnt + CW'(1);
    end
  end

  assign done = run && (cnt == LAST);
endmodule

// File: rtl/vr_ss_id_qual.sv
// Identification qualifier: stable once the code is valid and unchanged
// for STABLE_CYC consecutive edges. Runs in every phase.
module vr_ss_id_qual #(
  parameter int CODE_W     = 8,
  parameter int STABLE_CYC = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] id_code,
  input  logic              id_valid,
  output logic              stable
);
  localparam int SW = $clog2(STABLE_CYC + 1);
  localparam logic [SW-1:0] FULL = SW'(STABLE_CYC);

  logic [CODE_W-1:0] prev;
  logic [SW-1:0]     cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= '0;
      cnt  <= '0;
    end else begin
      prev <= id_code;
      if (!id_valid || (id_code != prev)) begin
        cnt <= '0;
      end else if (cnt != FULL) begin
        cnt <= cnt + SW'(1);
      end
    end
  end

  assign stable = id_valid && (cnt == FULL);
endmodule

// File: rtl/vr_ss_ramp.sv
// Reference register: moves one code toward goal per step strobe.
module vr_ss_ramp #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              step,
  input  logic [CODE_W-1:0] goal,
  output logic [CODE_W-1:0] code,
  output logic              at_goal
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      code <= '0;
    end else if (step && (code != goal)) begin
      if (code < goal) code <= code + CODE_W'(1);
      else             code <= code - CODE_W'(1);
    end
  end

  assign at_goal = (code == goal);
endmodule

// File: rtl/vr_softstart_seq.sv
module vr_softstart_seq
  import vr_ss_pkg::*;
#(
  parameter int CODE_W        = 8,
  parameter int MID_CODE      = 176,
  parameter int START_CYC     = 272000,
  parameter int HOLD_CYC      = 17000,
  parameter int SETTLE_CYC    = 17000,
  parameter int ID_STABLE_CYC = 100,
  parameter int OFFSET_STEPS  = 0,
  parameter int OFF_CODE      = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por_ok,
  input  logic              en_core,
  input  logic              en_io,
  input  logic              step_tick,
  input  logic [CODE_W-1:0] id_code,
  input  logic              id_valid,
  input  logic              fault_in,
  output logic [CODE_W-1:0] dac_code,
  output logic [2:0]        phase,
  output logic              ready
);
  localparam logic [CODE_W-1:0] MID_Q = CODE_W'(MID_CODE);
  localparam logic [CODE_W-1:0] OFS_Q = CODE_W'(OFFSET_STEPS);
  localparam logic [CODE_W-1:0] OFF_Q = CODE_W'(OFF_CODE);
  localparam int N_TMR = 3;

  function automatic int tmr_limit(input int g);
    case (g)
      0:       return START_CYC;
      1:       return HOLD_CYC;
      default: return SETTLE_CYC;
    endcase
  endfunction

  function automatic ss_phase_e tmr_phase(input int g);
    case (g)
      0:       return PH_DELAY;
      1:       return PH_HOLD;
      default: return PH_SETTLE;
    endcase
  endfunction

  ss_phase_e         state, nstate;
  logic [N_TMR-1:0]  tdone;
  logic              id_ok, at_goal, lost, off_seen, ramping;
  logic [CODE_W-1:0] target_q, id_target, goal;
  logic              ready_q;

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    vr_ss_timer #(.LIMIT(tmr_limit(g))) u_tmr (
      .clk  (clk),
      .rst  (rst),
      .run  (state == tmr_phase(g)),
      .done (tdone[g])
    );
  end

  vr_ss_id_qual #(.CODE_W(CODE_W), .STABLE_CYC(ID_STABLE_CYC)) u_qual (
    .clk      (clk),
    .rst      (rst),
    .id_code  (id_code),
    .id_valid (id_valid),
    .stable   (id_ok)
  );

  assign ramping   = (state == PH_RAMP_UP) || (state == PH_RAMP_ID);
  assign goal      = (state == PH_RAMP_UP) ? MID_Q : target_q;
  assign id_target = (id_code >= OFS_Q) ? (id_code - OFS_Q) : '0;
  assign lost      = !por_ok || !en_core || !en_io;
  assign off_seen  = id_valid && (id_code == OFF_Q);

  vr_ss_ramp #(.CODE_W(CODE_W)) u_ramp (
    .clk     (clk),
    .rst     (rst),
    .clr     ((nstate == PH_OFF) || (nstate == PH_FAULT)),
    .step    (step_tick && ramping),
    .goal    (goal),
    .code    (dac_code),
    .at_goal (at_goal)
  );

  always_comb begin
    nstate = state;
    if (lost) begin
      nstate = PH_OFF;
    end else if (fault_in && (state != PH_OFF) && (state != PH_FAULT)) begin
      nstate = PH_FAULT;
    end else begin
      case (state)
        PH_OFF:     if (!off_seen) nstate = PH_DELAY;
        PH_DELAY:   if (tdone[0]) nstate = PH_RAMP_UP;
        PH_RAMP_UP: if (at_goal) nstate = PH_HOLD;
        PH_HOLD:    if (tdone[1] && id_ok) nstate = off_seen ? PH_OFF : PH_RAMP_ID;
        PH_RAMP_ID: if (off_seen) nstate = PH_OFF;
                    else if (at_goal) nstate = PH_SETTLE;
        PH_SETTLE:  if (off_seen) nstate = PH_OFF;
                    else if (tdone[2]) nstate = PH_READY;
        PH_READY:   if (off_seen) nstate = PH_OFF;
        default:    nstate = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= PH_OFF;
      target_q <= '0;
      ready_q  <= 1'b0;
    end else begin
      state   <= nstate;
      ready_q <= (nstate == PH_READY);
      if ((state == PH_HOLD) && (nstate == PH_RAMP_ID)) target_q <= id_target;
    end
  end

  assign phase = state;
  assign ready = ready_q;
endmodule

// File: rtl/vr_softstart_seq_chk.sv
module vr_softstart_seq_chk #(
  parameter int CODE_W   = 8,
  parameter int OFF_CODE = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              por_ok,
  input logic              en_core,
  input logic              en_io,
  input logic              step_tick,
  input logic [CODE_W-1:0] id_code,
  input logic              id_valid,
  input logic              fault_in,
  input logic [CODE_W-1:0] dac_code,
  input logic [2:0]        phase,
  input logic              ready
);
  // R1
  shutdown_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(por_ok && en_core && en_io) |-> (phase == 3'd0 && dac_code == '0 && !ready));

  // R3
  step_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (dac_code != $past(dac_code) && dac_code != '0) |-> $past(step_tick));

  // R3
  step_size_chk: assert property (@(posedge clk) disable iff (rst)
    (dac_code != $past(dac_code) && dac_code != '0) |->
      (dac_code == $past(dac_code) + CODE_W'(1) || dac_code + CODE_W'(1) == $past(dac_code)));

  // R7
  ready_phase_chk: assert property (@(posedge clk) disable iff (rst)
    ready |-> phase == 3'd6);

  // R7
  ready_rise_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(phase) == 3'd5 && phase == 3'd6) |-> ready);

  // R8
  off_code_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(phase) == 3'd6 && $past(id_valid) && $past(id_code) == CODE_W'(OFF_CODE)
     && !$past(fault_in)) |-> (phase == 3'd0 && !ready));

  // R9
  fault_entry_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(fault_in) && $past(phase) != 3'd0 && $past(phase) != 3'd7
     && $past(por_ok && en_core && en_io)) |-> (phase == 3'd7 && !ready && dac_code == '0));
endmodule

bind vr_softstart_seq vr_softstart_seq_chk #(.CODE_W(CODE_W), .OFF_CODE(OFF_CODE)) u_chk (.*);

// File: tb/vr_softstart_seq_tb.sv
`timescale 1ns/1ps
module vr_softstart_seq_tb;
  localparam int W = 6, P_MID = 12, P_START = 5, P_HOLD = 6, P_SETTLE = 4;
  localparam int P_STAB = 3, P_OFS = 1, P_OFF = 0;

  logic clk = 0, rst = 1, por_ok = 0, en_core = 0, en_io = 0, step_tick = 0;
  logic [W-1:0] id_code = '0;
  logic id_valid = 0, fault_in = 0;
  logic [W-1:0] dac_code;
  logic [2:0] phase;
  logic ready;
  int checks = 0, fails = 0, tdiv = 0;

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    tdiv = (tdiv == 2) ? 0 : tdiv + 1;
    step_tick = (tdiv == 0);
  end

  vr_softstart_seq #(.CODE_W(W), .MID_CODE(P_MID), .START_CYC(P_START), .HOLD_CYC(P_HOLD),
    .SETTLE_CYC(P_SETTLE), .ID_STABLE_CYC(P_STAB), .OFFSET_STEPS(P_OFS), .OFF_CODE(P_OFF)) u_dut (
    .clk(clk), .rst(rst), .por_ok(por_ok), .en_core(en_core), .en_io(en_io),
    .step_tick(step_tick), .id_code(id_code), .id_valid(id_valid), .fault_in(fault_in),
    .dac_code(dac_code), .phase(phase), .ready(ready));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_phase(input int p);
    while (phase != 3'(p)) @(negedge clk);
  endtask

  task automatic enable_all();
    por_ok = 1; en_core = 1; en_io = 1;
  endtask

  task automatic shut();
    en_core = 0;
    @(negedge clk);
    chk(phase == 0 && dac_code == 0 && !ready, "R1 enable drop", int'(phase), 0);
    @(negedge clk);
  endtask

  task automatic bring_up(input int id);
    int n, ups, downs, bad, prev, exp_t, want_up, want_dn;
    id_code = W'(id); id_valid = 1; fault_in = 0;
    enable_all();
    @(negedge clk);
    chk(phase == 1, "R2 enter delay", int'(phase), 1);
    n = 0;
    while (phase == 1) begin n++; @(negedge clk); end
    chk(n == P_START, "R2 delay length", n, P_START);
    ups = 0; bad = 0; prev = int'(dac_code);
    while (phase == 2) begin
      if (int'(dac_code) != prev) begin
        if (int'(dac_code) == prev + 1) ups++; else bad++;
        prev = int'(dac_code);
      end
      @(negedge clk);
    end
    chk(bad == 0, "R3 first ramp step size", bad, 0);
    chk(ups == P_MID, "R4 first ramp steps", ups, P_MID);
    chk(phase == 3 && dac_code == W'(P_MID), "R4 hold level", int'(dac_code), P_MID);
    n = 0;
    while (phase == 3) begin n++; @(negedge clk); end
    chk(n == P_HOLD, "R5 hold length", n, P_HOLD);
    exp_t = (id >= P_OFS) ? id - P_OFS : 0;
    want_up = (exp_t > P_MID) ? exp_t - P_MID : 0;
    want_dn = (exp_t < P_MID) ? P_MID - exp_t : 0;
    chk(phase == 4, "R6 second ramp entered", int'(phase), 4);
    ups = 0; downs = 0; bad = 0; prev = int'(dac_code);
    while (phase == 4) begin
      if (int'(dac_code) != prev) begin
        if (int'(dac_code) == prev + 1) ups++;
        else if (int'(dac_code) == prev - 1) downs++;
        else bad++;
        prev = int'(dac_code);
      end
      @(negedge clk);
    end
    chk(bad == 0, "R3 second ramp step size", bad, 0);
    chk(ups == want_up && downs == want_dn, "R6 ramp direction", ups - downs, want_up - want_dn);
    chk(int'(dac_code) == exp_t, "R6 final code", int'(dac_code), exp_t);
    n = 0;
    while (phase == 5) begin
      if (ready) bad++;
      n++; @(negedge clk);
    end
    chk(n == P_SETTLE && bad == 0, "R7 settle length", n, P_SETTLE);
    chk(phase == 6 && ready, "R7 ready", int'(ready), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    enable_all();
    repeat (4) @(negedge clk);
    chk(phase == 0 && dac_code == 0 && !ready, "R1 reset state", int'(phase), 0);
    por_ok = 0; en_core = 0; en_io = 0;
    rst = 0;
    repeat (3) @(negedge clk);
    chk(phase == 0 && !ready, "R1 idle with enables low", int'(phase), 0);

    for (int id = 1; id <= 40; id++) begin
      bring_up(id);
      shut();
    end

    // R1: supply loss mid-ramp
    id_code = 6'd20; id_valid = 1; enable_all();
    wait_phase(2);
    while (dac_code < 3) @(negedge clk);
    por_ok = 0;
    @(negedge clk);
    chk(phase == 0 && dac_code == 0, "R1 supply loss", int'(dac_code), 0);
    en_core = 0;
    @(negedge clk);

    // R5: late and absent identification code
    id_valid = 0; id_code = 0; enable_all();
    wait_phase(3);
    repeat (40) @(negedge clk);
    chk(phase == 3 && dac_code == W'(P_MID), "R5 waits without code", int'(phase), 3);
    id_code = 6'd20; id_valid = 1;
    repeat (P_STAB + 1) @(negedge clk);
    chk(phase == 3, "R5 still qualifying", int'(phase), 3);
    @(negedge clk);
    chk(phase == 4, "R5 leaves after qualify", int'(phase), 4);
    wait_phase(6);
    chk(dac_code == 6'd19, "R6 late code target", int'(dac_code), 19);

    // R8: off code while ready
    id_code = W'(P_OFF);
    @(negedge clk);
    chk(phase == 0 && dac_code == 0 && !ready, "R8 off code in ready", int'(phase), 0);
    repeat (5) @(negedge clk);
    chk(phase == 0, "R8 off held", int'(phase), 0);
    id_code = 6'd20;
    @(negedge clk);
    chk(phase == 1, "R8 restart after off code", int'(phase), 1);
    shut();

    // R8: off code qualified at end of hold
    id_valid = 0; enable_all();
    wait_phase(3);
    repeat (10) @(negedge clk);
    id_code = W'(P_OFF); id_valid = 1;
    repeat (P_STAB + 1) @(negedge clk);
    chk(phase == 3, "R8 off code qualifying", int'(phase), 3);
    @(negedge clk);
    chk(phase == 0 && dac_code == 0, "R8 off code at hold end", int'(phase), 0);
    repeat (4) @(negedge clk);
    chk(phase == 0, "R8 off stays", int'(phase), 0);
    shut();

    // R9: fault during second ramp
    id_code = 6'd30; id_valid = 1; enable_all();
    wait_phase(4);
    fault_in = 1;
    @(negedge clk);
    chk(phase == 7 && dac_code == 0 && !ready, "R9 fault entry", int'(phase), 7);
    fault_in = 0;
    repeat (10) @(negedge clk);
    chk(phase == 7 && dac_code == 0, "R9 fault latched", int'(phase), 7);
    en_io = 0;
    @(negedge clk);
    chk(phase == 0, "R9 fault cleared by enable", int'(phase), 0);
    en_io = 1;
    wait_phase(6);
    fault_in = 1;
    @(negedge clk);
    chk(phase == 7 && !ready, "R9 fault in ready", int'(ready), 0);
    fault_in = 0;
    shut();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule